// File: doc/BRIEF.md
# Three-Group Interrupt Cause Aggregator

The block gathers interrupt events from three sources: transmit, receive and miscellaneous. Each source has its own cause group. An event pulse on an input bit sets the matching cause bit, and the bit stays set until the host clears it.

Each group has a per-bit mask. The host changes that mask through two write-only strobes: one sets mask bits and one clears them. Each group also has a clear-mode setting. In one mode a read of the cause register empties it. In the other mode the host writes ones to the bits it wants cleared.

A summary word holds one bit per group. A summary bit latches whenever its group has an unmasked cause bit set. Reading the summary word clears it. A software mask sits in front of the summary word and gates the single host interrupt line.

Software uses the block in a fixed order. It reads the summary word to see which groups are pending. It then reads each of those groups and acknowledges them in that group's chosen mode. Finally it unmasks again through the mask-clear strobe.

Top module: `irq_cause_agg`

## Requirements
- R1: After reset every cause bit is 0, every group mask reads 0xFFFFFFFF, every clear mode reads 0, the software mask reads 0xFFFFFFFF and `irq_o` is low.
- R2: A 1 on an event input bit sets the matching cause bit at the next clock edge, and the bit stays set until it is cleared.
- R3: In write-1-to-clear mode, a write to a cause register clears exactly the bits that are 1 in the written data. A read of the cause register leaves it unchanged.
- R4: In clear-on-read mode, a read of a cause register returns its value and clears all of its bits at that edge. A write to the cause register has no effect.
- R5: A write of 0xFFFFFFFF to a group's mode register selects clear-on-read, and any other value selects write-1-to-clear. The mode register reads back 0xFFFFFFFF or 0 to show the active mode.
- R6: Writing to mask-set sets every mask bit that is 1 in the data, and writing to mask-clear clears them. Other mask bits keep their value. The mask-value register reads the current mask.
- R7: The masked-cause register reads cause AND NOT mask.
- R8: Summary bit 0 (transmit), bit 1 (receive) and bit 2 (miscellaneous) sets at the edge after that group's masked cause becomes nonzero. Summary bits 31:3 always read 0.
- R9: A read of the summary word clears it at that edge. A bit whose group is still pending sets again at that same edge.
- R10: `irq_o` is high exactly while some summary bit is set whose software-mask bit is 0. Writing 0xFFFFFFF8 to the software mask enables all three groups.
- R11: An event on a bit in the same cycle as a clear of that bit wins, and the bit stays set.
- R12: `addr_i` is a word index. Group g (transmit 0, receive 1, miscellaneous 2) occupies indices 8g+0 (cause), 8g+1 (mask-set), 8g+2 (mask-clear), 8g+3 (mask value), 8g+4 (masked cause) and 8g+5 (mode). Index 24 is the summary word and index 25 is the software mask. Write-only and unused indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | 96 | Event pulses; bits 32g+31:32g belong to group g |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (triggers read side effects) |
| addr_i | input | 5 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The assertions assume that a write and a read never happen in the same cycle. They also assume that event pulses arriving during a write are meant to be checked only for the collision rule. The bench keeps to this by driving each access from its own task, one strobe per cycle. Events are raised alone, except in the scenario that deliberately overlaps an event with a clear. Inputs change only on the falling edge, so each access meets exactly one rising edge.

// File: rtl/irq_agg_pkg.sv
// Shared constants for the interrupt cause aggregator.
// Assumes word-indexed register access; group count is fixed by the map layout.
package irq_agg_pkg;
    localparam int NUM_GRP  = 3;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int SUM_GRP  = 3;   // group field value that selects summary regs

    typedef enum logic [2:0] {
        OFS_CAUSE  = 3'd0,
        OFS_MSET   = 3'd1,
        OFS_MCLR   = 3'd2,
        OFS_MVAL   = 3'd3,
        OFS_MCAUSE = 3'd4,
        OFS_MODE   = 3'd5
    } grp_ofs_e;

    localparam logic [2:0] OFS_SUM    = 3'd0;
    localparam logic [2:0] OFS_SWMASK = 3'd1;
endpackage

// File: rtl/cause_group.sv
// One cause group: sticky cause bits, per-bit mask, selectable clear mode.
// Assumes at most one of the access strobes is high per cycle.
module cause_group #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic         cause_rd_i,
    input  logic         cause_wr_i,
    input  logic         mset_wr_i,
    input  logic         mclr_wr_i,
    input  logic         mode_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cause_o,
    output logic [W-1:0] mask_o,
    output logic         cor_o,
    output logic         pend_o
);
    logic [W-1:0] cause_q, mask_q, clr;
    logic         cor_q;

    // Bits to clear this cycle, chosen by the active clear mode.
    always_comb begin
        clr = '0;
        if (cor_q && cause_rd_i)       clr = cause_q;
        else if (!cor_q && cause_wr_i) clr = wdata_i;
    end

    // Cause register: clear first, then events (events win).
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr) | ev_i;
    end

    // Mask register driven by separate set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mset_wr_i) mask_q <= mask_q | wdata_i;
        else if (mclr_wr_i) mask_q <= mask_q & ~wdata_i;
    end

    // Clear mode: all ones selects clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n)         cor_q <= 1'b0;
        else if (mode_wr_i) cor_q <= &wdata_i;
    end

    assign cause_o = cause_q;
    assign mask_o  = mask_q;
    assign cor_o   = cor_q;
    assign pend_o  = |(cause_q & ~mask_q);

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((cause_q & $past(ev_i)) == $past(ev_i)));
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cor_q && cause_wr_i && ev_i == '0) |=> ((cause_q & $past(wdata_i)) == '0));
    p_cor_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_q && cause_rd_i && ev_i == '0) |=> (cause_q == '0));
    p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mset_wr_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
    p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mclr_wr_i && !mset_wr_i) |=> ((mask_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/irq_summary.sv
// Summary word: one latched bit per group, cleared on read, gated by a software mask.
// Assumes pend_i is the per-group "unmasked cause present" indication.
module irq_summary #(
    parameter int NG = 3,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NG-1:0] pend_i,
    input  logic          sum_rd_i,
    input  logic          sw_wr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [NG-1:0] sum_o,
    output logic [W-1:0]  swmask_o,
    output logic          irq_o
);
    logic [NG-1:0] sum_q;
    logic [W-1:0]  sw_q;

    // Summary bits latch pending groups; a read clears, pending re-sets.
    always_ff @(posedge clk) begin
        if (!rst_n)        sum_q <= '0;
        else if (sum_rd_i) sum_q <= pend_i;
        else               sum_q <= sum_q | pend_i;
    end

    // Software mask over the summary word.
    always_ff @(posedge clk) begin
        if (!rst_n)       sw_q <= '1;
        else if (sw_wr_i) sw_q <= wdata_i;
    end

    assign sum_o    = sum_q;
    assign swmask_o = sw_q;
    assign irq_o    = |(sum_q & ~sw_q[NG-1:0]);

    p_pend_latches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i != '0) |=> ((sum_q & $past(pend_i)) == $past(pend_i)));
    p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & ~sw_q[NG-1:0]) != '0 && !sw_wr_i) |=> irq_o);
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_rd_i && pend_i == '0) |=> (sum_q == '0));
endmodule

// File: rtl/irq_cause_agg.sv
// Top: address decode, three cause groups, summary word and host interrupt.
// Assumes word-indexed accesses with one strobe (read or write) per cycle.
module irq_cause_agg
    import irq_agg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_GRP*DATA_W-1:0] ev_i,
    input  logic                      wr_en_i,
    input  logic                      rd_en_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic                      irq_o
);
    localparam int GSEL_W = ADDR_W - 3;

    logic [GSEL_W-1:0] gsel;
    logic [2:0]        ofs;
    logic [DATA_W-1:0] cause  [NUM_GRP];
    logic [DATA_W-1:0] mask   [NUM_GRP];
    logic [NUM_GRP-1:0] cor, pend, sum;
    logic [DATA_W-1:0] swmask;
    logic              sum_sel;

    assign gsel    = addr_i[ADDR_W-1:3];
    assign ofs     = addr_i[2:0];
    assign sum_sel = (gsel == GSEL_W'(SUM_GRP));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic hit;
        assign hit = (gsel == GSEL_W'(g));
        cause_group #(.W(DATA_W)) u_grp (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_i       (ev_i[g*DATA_W +: DATA_W]),
            .cause_rd_i (rd_en_i && hit && ofs == OFS_CAUSE),
            .cause_wr_i (wr_en_i && hit && ofs == OFS_CAUSE),
            .mset_wr_i  (wr_en_i && hit && ofs == OFS_MSET),
            .mclr_wr_i  (wr_en_i && hit && ofs == OFS_MCLR),
            .mode_wr_i  (wr_en_i && hit && ofs == OFS_MODE),
            .wdata_i    (wdata_i),
            .cause_o    (cause[g]),
            .mask_o     (mask[g]),
            .cor_o      (cor[g]),
            .pend_o     (pend[g])
        );
    end

    irq_summary #(.NG(NUM_GRP), .W(DATA_W)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .sum_rd_i (rd_en_i && sum_sel && ofs == OFS_SUM),
        .sw_wr_i  (wr_en_i && sum_sel && ofs == OFS_SWMASK),
        .wdata_i  (wdata_i),
        .sum_o    (sum),
        .swmask_o (swmask),
        .irq_o    (irq_o)
    );

    // Read mux: group registers, then summary registers; others read zero.
    always_comb begin
        rdata_o = '0;
        if (sum_sel) begin
            if (ofs == OFS_SUM)         rdata_o = DATA_W'(sum);
            else if (ofs == OFS_SWMASK) rdata_o = swmask;
        end else begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (gsel == GSEL_W'(g)) begin
                    case (ofs)
                        OFS_CAUSE:  rdata_o = cause[g];
                        OFS_MVAL:   rdata_o = mask[g];
                        OFS_MCAUSE: rdata_o = cause[g] & ~mask[g];
                        OFS_MODE:   rdata_o = {DATA_W{cor[g]}};
                        default:    rdata_o = '0;
                    endcase
                end
            end
        end
    end

    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && rd_en_i));
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !irq_o);
endmodule

// File: tb/tb_irq_cause_agg.sv
module tb_irq_cause_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] ev = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_cause_agg dut (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [4:0] ix(input int g, input int o);
        return 5'(8 * g + o);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Read with side effect; data captured before the clearing edge.
    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(input int g, input logic [31:0] bits);
        @(negedge clk); ev[g*32 +: 32] = bits;
        @(negedge clk); ev = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int g = 0; g < 3; g++) begin
            rd(ix(g, 0), d); check("R1 cause", d, 32'h0);
            rd(ix(g, 3), d); check("R1 mask", d, 32'hFFFF_FFFF);
            rd(ix(g, 5), d); check("R1 mode", d, 32'h0);
        end
        rd(5'd25, d); check("R1 swmask", d, 32'hFFFF_FFFF);
        check("R1 irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        pulse(0, 32'h0000_00F0);
        rd(ix(0, 0), d); check("R2 set", d, 32'h0000_00F0);
        rd(ix(0, 0), d); check("R3 read keeps", d, 32'h0000_00F0);
        wr(ix(0, 0), 32'h0000_0030);
        rd(ix(0, 0), d); check("R3 partial clear", d, 32'h0000_00C0);
        wr(ix(0, 0), 32'h0000_00C0);
        rd(ix(0, 0), d); check("R3 all clear", d, 32'h0);
    endtask

    task automatic t_mode_cor();
        logic [31:0] d;
        wr(ix(1, 5), 32'h7FFF_FFFF);
        rd(ix(1, 5), d); check("R5 partial ones is w1c", d, 32'h0);
        wr(ix(1, 5), 32'hFFFF_FFFF);
        rd(ix(1, 5), d); check("R5 cor selected", d, 32'hFFFF_FFFF);
        pulse(1, 32'h8000_0001);
        wr(ix(1, 0), 32'hFFFF_FFFF);
        rd(ix(1, 0), d); check("R4 write ignored", d, 32'h8000_0001);
        rd(ix(1, 0), d); check("R4 read cleared", d, 32'h0);
        wr(ix(1, 5), 32'h0);
        rd(ix(1, 5), d); check("R5 back to w1c", d, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(ix(2, 2), 32'h0000_FF00);
        rd(ix(2, 3), d); check("R6 mask clear", d, 32'hFFFF_00FF);
        wr(ix(2, 1), 32'h0000_0F00);
        rd(ix(2, 3), d); check("R6 mask set", d, 32'hFFFF_0FFF);
        pulse(2, 32'h0000_3300);
        rd(ix(2, 4), d); check("R7 masked cause", d, 32'h0000_3000);
        wr(ix(2, 0), 32'h0000_3300);
        wr(ix(2, 1), 32'hFFFF_FFFF);
        rd(ix(2, 3), d); check("R6 remask", d, 32'hFFFF_FFFF);
        rd(ix(0, 1), d); check("R12 write-only reads zero", d, 32'h0);
    endtask

    task automatic t_summary();
        logic [31:0] d;
        rd(5'd24, d);                       // flush anything latched earlier
        pulse(0, 32'h0000_0001);
        rd(5'd24, d); check("R8 masked group silent", d, 32'h0);
        wr(ix(0, 2), 32'h0000_0001);
        @(negedge clk);
        check("R10 sw-masked irq low", {31'd0, irq}, 32'h0);
        wr(5'd25, 32'hFFFF_FFF8);
        check("R10 irq high", {31'd0, irq}, 32'h1);
        rd(5'd24, d); check("R8 tx bit", d, 32'h0000_0001);
        rd(5'd24, d); check("R9 re-set while pending", d, 32'h0000_0001);
        wr(ix(0, 0), 32'h0000_0001);
        rd(5'd24, d); check("R9 latched after clear", d, 32'h0000_0001);
        rd(5'd24, d); check("R9 cleared by read", d, 32'h0);
        check("R10 irq low", {31'd0, irq}, 32'h0);
        wr(ix(1, 2), 32'h0000_0004);
        pulse(1, 32'h0000_0004);
        @(negedge clk);
        rd(5'd24, d); check("R8 rx bit", d, 32'h0000_0002);
        wr(ix(1, 0), 32'h0000_0004);
        wr(ix(1, 1), 32'h0000_0004);
        rd(5'd24, d);
        wr(ix(0, 1), 32'h0000_0001);
        wr(5'd25, 32'hFFFF_FFFF);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        pulse(2, 32'h0000_0010);
        @(negedge clk);
        wr_en = 1'b1; addr = ix(2, 0); wdata = 32'h0000_0010; ev[64 +: 32] = 32'h0000_0010;
        @(negedge clk);
        wr_en = 1'b0; ev = '0;
        rd(ix(2, 0), d); check("R11 event beats clear", d, 32'h0000_0010);
        wr(ix(2, 0), 32'h0000_0010);
        rd(ix(2, 0), d); check("R11 later clear works", d, 32'h0);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_w1c();
        t_mode_cor();
        t_mask();
        t_summary();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule